// File: doc/BRIEF.md
# SDRAM Bank Timing and Page-Policy Manager

This block sits between a memory request front end and the SDRAM command issuer. It keeps, for each internal bank, whether a row is open and which one. For each incoming request it decides whether the request is a page hit, a page miss or an access to a closed bank. It then emits one command per cycle, and only once the programmed cycle timing allows that command. The commands are activate, read, write, precharge and refresh.

Requests arrive on a valid/ready handshake and are served strictly in order. The block can also close a page on its own, for three reasons: the page has served a programmed number of consecutive hits, it has sat unused for a programmed number of cycles, or a periodic refresh is due. None of these closures ever cuts short a bank's minimum open time. The refresh period is a parameter in clock cycles. A configuration bit marks each refresh command as covering two rows, for devices with more rows than the period was sized for.

Top module: `sdram_bank_mgr`

## Requirements
- R1: A synchronous active-high reset leaves every bank closed, every timing counter expired and the refresh counter at zero. After reset the command is NOP and `req_ready` is low. A first request to any bank is therefore activated in the same cycle it is presented.
- R2: Command encoding on `cmd_op`: 0 NOP, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh. A request to a closed bank whose timing has expired gives an activate with the request's bank and row, and the access follows in the next cycle.
- R3: A request whose row is already open in its bank gives the access in the same cycle, with `req_ready` high. The access is a read when `req_write` is 0 and a write when it is 1, and it echoes the request's bank, row and column.
- R4: A request to a bank holding a different row gives a precharge of that bank, then an activate of the new row, then the access.
- R5: A precharge is never issued to a bank earlier than `cfg_tras` cycles after its activate. A precharge that is held back only by this rule is issued exactly in that cycle.
- R6: The precharge time is 2 cycles when `cfg_trp_long` is 0 and 3 when it is 1. A bank is activated no earlier than that many cycles after its precharge, and no earlier than `cfg_tras` plus that time after its previous activate.
- R7: Two activate commands are never issued in adjacent cycles.
- R8: Once an open page has served `cfg_hit_limit` accesses since its activate, it is precharged before any further access to it.
- R9: With `cfg_idle_limit` L above zero, a page that has gone L cycles without an access is precharged in the cycle L+1 after its last access, subject to R5.
- R10: With `cfg_idle_limit` zero, a page is precharged at the first cycle allowed by R5 once it has been accessed (close-page policy).
- R11: A refresh falls due every `REF_INTERVAL` cycles. While one is pending, no activate or access is issued and `req_ready` stays low. Each open bank is precharged once its own R5 time is met. The refresh command is issued once all banks are closed and the precharge time has passed since each bank's precharge.
- R12: `cmd_ref_dual` is high exactly on refresh commands issued while `cfg_ref_dual` is 1.
- R13: `req_ready` is high only in a cycle whose command is the access for the presented request, so requests complete in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| cfg_tras | input | TRAS_W | Minimum open time in cycles |
| cfg_trp_long | input | 1 | Precharge time select: 0 gives 2 cycles, 1 gives 3 |
| cfg_hit_limit | input | HIT_W | Accesses per activate before a forced close |
| cfg_idle_limit | input | IDLE_W | Unused cycles before auto-close; 0 selects close-page |
| cfg_ref_dual | input | 1 | Each refresh covers two rows |
| cmd_op | output | 3 | Command code |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Row for activate and access |
| cmd_col | output | COL_W | Column for access |
| cmd_ref_dual | output | 1 | Refresh covers two rows |

## Verification
The collision that matters is a refresh falling due while a request waits on a bank that was opened only a few cycles earlier. The refresh must win, but it may close that bank only after its minimum open time. The bench provokes this by opening a page just before the refresh counter expires and presenting a request as it does. It then judges the result from the command stream. The precharge must come exactly `cfg_tras` after the activate and the refresh exactly the precharge time later, and the held request must complete two cycles after the refresh. Randomised traffic over every timing setting also overlaps forced page closes with requests to other banks, and every command is checked against the bank shadow state.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_PRE = 3'd4,
      CMD_REF = 3'd5
   } sdm_cmd_e;
endpackage

// File: rtl/sdm_bank_track.sv
// Per-bank state: open row, elapsed-time counters, hit and idle counters.
module sdm_bank_track #(
   parameter int ROW_W  = 13,
   parameter int TRAS_W = 4,
   parameter int HIT_W  = 7,
   parameter int IDLE_W = 8,
   parameter int CNT_W  = TRAS_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              do_act,
   input  logic              do_pre,
   input  logic              do_acc,
   input  logic [ROW_W-1:0]  act_row,
   input  logic [TRAS_W-1:0] tras,
   input  logic [CNT_W-1:0]  trp_cyc,
   input  logic [HIT_W-1:0]  hit_limit,
   input  logic [IDLE_W-1:0] idle_limit,
   output logic              is_open,
   output logic [ROW_W-1:0]  open_row,
   output logic              pre_ok,
   output logic              act_ok,
   output logic              pre_done,
   output logic              close_due
);
   logic [CNT_W-1:0]  since_act, since_pre;
   logic [HIT_W-1:0]  hits;
   logic [IDLE_W-1:0] idle;
   logic              touched;
   logic [CNT_W-1:0]  tras_x, trc_x;

   assign tras_x = {1'b0, tras};
   assign trc_x  = tras_x + trp_cyc;

   always_ff @(posedge clk) begin
      if (rst) begin
         is_open   <= 1'b0;
         open_row  <= '0;
         since_act <= '1;
         since_pre <= '1;
         hits      <= '0;
         idle      <= '0;
         touched   <= 1'b0;
      end else begin
         if (do_act) begin
            is_open   <= 1'b1;
            open_row  <= act_row;
            since_act <= CNT_W'(1);
            hits      <= '0;
            idle      <= '0;
            touched   <= 1'b0;
         end else begin
            if (since_act != '1) since_act <= since_act + 1'b1;
            if (do_acc) begin
               if (hits != '1) hits <= hits + 1'b1;
               idle    <= '0;
               touched <= 1'b1;
            end else if (idle != '1) begin
               idle <= idle + 1'b1;
            end
         end
         if (do_pre) begin
            is_open   <= 1'b0;
            since_pre <= CNT_W'(1);
         end else if (since_pre != '1) begin
            since_pre <= since_pre + 1'b1;
         end
      end
   end

   assign pre_ok    = is_open && (since_act >= tras_x);
   assign pre_done  = since_pre >= trp_cyc;
   assign act_ok    = !is_open && pre_done && (since_act >= trc_x);
   assign close_due = is_open &&
                      ((hits >= hit_limit) ||
                       ((idle >= idle_limit) && ((idle_limit != '0) || touched)));
endmodule

// File: rtl/sdm_ref_timer.sv
// Free-running refresh interval counter with a sticky pending flag.
module sdm_ref_timer #(
   parameter int INTERVAL = 1560,
   localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1
) (
   input  logic clk,
   input  logic rst,
   input  logic ref_issued,
   output logic ref_pending
);
   logic [CW-1:0] cnt;
   logic          wrap;

   assign wrap = (cnt == CW'(INTERVAL - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt         <= '0;
         ref_pending <= 1'b0;
      end else begin
         cnt <= wrap ? '0 : cnt + 1'b1;
         if (wrap)            ref_pending <= 1'b1;
         else if (ref_issued) ref_pending <= 1'b0;
      end
   end
endmodule

// File: rtl/sdm_sched.sv
// One command per cycle: closures first, then refresh, then the head request.
module sdm_sched
   import sdm_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 2,
   parameter int ROW_W     = 13
) (
   input  logic                 ref_pending,
   input  logic                 act_last,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [BANK_W-1:0]    req_bank,
   input  logic [ROW_W-1:0]     req_row,
   input  logic [NUM_BANKS-1:0] bk_open,
   input  logic [NUM_BANKS-1:0] bk_pre_ok,
   input  logic [NUM_BANKS-1:0] bk_act_ok,
   input  logic [NUM_BANKS-1:0] bk_pre_done,
   input  logic [NUM_BANKS-1:0] bk_close_due,
   input  logic [ROW_W-1:0]     bk_row [NUM_BANKS],
   output sdm_cmd_e             op,
   output logic [BANK_W-1:0]    op_bank,
   output logic                 grant
);
   logic              close_any;
   logic [BANK_W-1:0] close_idx;
   logic              row_hit;

   always_comb begin
      close_any = 1'b0;
      close_idx = '0;
      for (int i = NUM_BANKS - 1; i >= 0; i--) begin
         if (bk_pre_ok[i] && (ref_pending || bk_close_due[i])) begin
            close_any = 1'b1;
            close_idx = BANK_W'(i);
         end
      end
   end

   assign row_hit = (bk_row[req_bank] == req_row);

   always_comb begin
      op      = CMD_NOP;
      op_bank = '0;
      grant   = 1'b0;
      if (close_any) begin
         op      = CMD_PRE;
         op_bank = close_idx;
      end else if (ref_pending) begin
         if ((bk_open == '0) && (&bk_pre_done)) op = CMD_REF;
      end else if (req_valid) begin
         op_bank = req_bank;
         if (bk_open[req_bank]) begin
            if (row_hit && !bk_close_due[req_bank]) begin
               op    = req_write ? CMD_WR : CMD_RD;
               grant = 1'b1;
            end else if (!row_hit && bk_pre_ok[req_bank]) begin
               op = CMD_PRE;
            end
         end else if (bk_act_ok[req_bank] && !act_last) begin
            op = CMD_ACT;
         end
      end
   end
endmodule

// File: rtl/sdram_bank_mgr.sv
module sdram_bank_mgr
   import sdm_pkg::*;
#(
   parameter int NUM_BANKS    = 4,
   parameter int ROW_W        = 13,
   parameter int COL_W        = 10,
   parameter int TRAS_W       = 4,
   parameter int HIT_W        = 7,
   parameter int IDLE_W       = 8,
   parameter int REF_INTERVAL = 1560,
   localparam int BANK_W      = $clog2(NUM_BANKS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic [TRAS_W-1:0] cfg_tras,
   input  logic              cfg_trp_long,
   input  logic [HIT_W-1:0]  cfg_hit_limit,
   input  logic [IDLE_W-1:0] cfg_idle_limit,
   input  logic              cfg_ref_dual,
   output logic [2:0]        cmd_op,
   output logic [BANK_W-1:0] cmd_bank,
   output logic [ROW_W-1:0]  cmd_row,
   output logic [COL_W-1:0]  cmd_col,
   output logic              cmd_ref_dual
);
   localparam int CNT_W = TRAS_W + 1;

   if (NUM_BANKS < 2 || NUM_BANKS != (1 << BANK_W)) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (REF_INTERVAL < 4) begin : g_bad_ref
      $error("REF_INTERVAL must be at least 4");
   end
   if (HIT_W < 7) begin : g_bad_hit
      $error("HIT_W must hold a hit limit of 64");
   end
   if (TRAS_W < 3) begin : g_bad_tras
      $error("TRAS_W must hold an open time of at least 7");
   end

   logic [NUM_BANKS-1:0] bk_open, bk_pre_ok, bk_act_ok, bk_pre_done, bk_close_due;
   logic [ROW_W-1:0]     bk_row [NUM_BANKS];
   logic [CNT_W-1:0]     trp_cyc;
   logic                 ref_pending, act_last, grant;
   sdm_cmd_e             op;
   logic [BANK_W-1:0]    op_bank;

   assign trp_cyc = cfg_trp_long ? CNT_W'(3) : CNT_W'(2);

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      sdm_bank_track #(
         .ROW_W(ROW_W), .TRAS_W(TRAS_W), .HIT_W(HIT_W),
         .IDLE_W(IDLE_W), .CNT_W(CNT_W)
      ) u_trk (
         .clk       (clk),
         .rst       (rst),
         .do_act    ((op == CMD_ACT) && (op_bank == BANK_W'(i))),
         .do_pre    ((op == CMD_PRE) && (op_bank == BANK_W'(i))),
         .do_acc    (grant && (op_bank == BANK_W'(i))),
         .act_row   (req_row),
         .tras      (cfg_tras),
         .trp_cyc   (trp_cyc),
         .hit_limit (cfg_hit_limit),
         .idle_limit(cfg_idle_limit),
         .is_open   (bk_open[i]),
         .open_row  (bk_row[i]),
         .pre_ok    (bk_pre_ok[i]),
         .act_ok    (bk_act_ok[i]),
         .pre_done  (bk_pre_done[i]),
         .close_due (bk_close_due[i])
      );
   end

   sdm_ref_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
      .clk        (clk),
      .rst        (rst),
      .ref_issued (op == CMD_REF),
      .ref_pending(ref_pending)
   );

   sdm_sched #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_sched (
      .ref_pending (ref_pending),
      .act_last    (act_last),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_bank    (req_bank),
      .req_row     (req_row),
      .bk_open     (bk_open),
      .bk_pre_ok   (bk_pre_ok),
      .bk_act_ok   (bk_act_ok),
      .bk_pre_done (bk_pre_done),
      .bk_close_due(bk_close_due),
      .bk_row      (bk_row),
      .op          (op),
      .op_bank     (op_bank),
      .grant       (grant)
   );

   always_ff @(posedge clk) begin
      if (rst) act_last <= 1'b0;
      else     act_last <= (op == CMD_ACT);
   end

   assign req_ready    = grant;
   assign cmd_op       = op;
   assign cmd_bank     = op_bank;
   assign cmd_row      = ((op == CMD_ACT) || grant) ? req_row : '0;
   assign cmd_col      = grant ? req_col : '0;
   assign cmd_ref_dual = (op == CMD_REF) && cfg_ref_dual;
endmodule

// File: rtl/sdram_bank_mgr_chk.sv
// Protocol checker built from the command port only, bound to the top.
module sdram_bank_mgr_chk #(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 2,
   parameter int ROW_W     = 13,
   parameter int TRAS_W    = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic              req_ready,
   input logic [BANK_W-1:0] req_bank,
   input logic [ROW_W-1:0]  req_row,
   input logic [TRAS_W-1:0] cfg_tras,
   input logic              cfg_trp_long,
   input logic [2:0]        cmd_op,
   input logic [BANK_W-1:0] cmd_bank,
   input logic [ROW_W-1:0]  cmd_row,
   input logic              cmd_ref_dual
);
   logic [7:0]           sa [NUM_BANKS];
   logic [7:0]           sp [NUM_BANKS];
   logic [ROW_W-1:0]     rw [NUM_BANKS];
   logic [NUM_BANKS-1:0] om;
   logic [7:0]           trp_v, tras_v;

   assign trp_v  = cfg_trp_long ? 8'd3 : 8'd2;
   assign tras_v = 8'(cfg_tras);

   always_ff @(posedge clk) begin
      for (int i = 0; i < NUM_BANKS; i++) begin
         if (rst) begin
            sa[i] <= '1;
            sp[i] <= '1;
            rw[i] <= '0;
            om[i] <= 1'b0;
         end else begin
            if (cmd_op == 3'd1 && cmd_bank == BANK_W'(i)) begin
               sa[i] <= 8'd1;
               rw[i] <= cmd_row;
               om[i] <= 1'b1;
            end else if (sa[i] != '1) begin
               sa[i] <= sa[i] + 8'd1;
            end
            if (cmd_op == 3'd4 && cmd_bank == BANK_W'(i)) begin
               sp[i] <= 8'd1;
               om[i] <= 1'b0;
            end else if (sp[i] != '1) begin
               sp[i] <= sp[i] + 8'd1;
            end
         end
      end
   end

   p_tras_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (cmd_op == 3'd4) |-> (om[cmd_bank] && sa[cmd_bank] >= tras_v));
   p_trp_trc_r6: assert property (@(posedge clk) disable iff (rst)
      (cmd_op == 3'd1) |-> (!om[cmd_bank] && sp[cmd_bank] >= trp_v &&
                            sa[cmd_bank] >= tras_v + trp_v));
   p_act_gap_r7: assert property (@(posedge clk) disable iff (rst)
      (cmd_op == 3'd1) |=> (cmd_op != 3'd1));
   p_ref_idle_r11: assert property (@(posedge clk) disable iff (rst)
      (cmd_op == 3'd5) |-> (om == '0));
   p_hit_row_r3: assert property (@(posedge clk) disable iff (rst)
      (cmd_op == 3'd2 || cmd_op == 3'd3) |-> (om[cmd_bank] && rw[cmd_bank] == cmd_row));
   p_ready_access_r13: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> (req_valid && (cmd_op == 3'd2 || cmd_op == 3'd3) &&
                     cmd_bank == req_bank && cmd_row == req_row));
   p_dual_flag_r12: assert property (@(posedge clk) disable iff (rst)
      cmd_ref_dual |-> (cmd_op == 3'd5));
endmodule

bind sdram_bank_mgr sdram_bank_mgr_chk #(
   .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W), .TRAS_W(TRAS_W)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .req_bank    (req_bank),
   .req_row     (req_row),
   .cfg_tras    (cfg_tras),
   .cfg_trp_long(cfg_trp_long),
   .cmd_op      (cmd_op),
   .cmd_bank    (cmd_bank),
   .cmd_row     (cmd_row),
   .cmd_ref_dual(cmd_ref_dual)
);

// File: tb/sdram_bank_mgr_tb.sv
module sdram_bank_mgr_tb;
   localparam int NB = 4;
   localparam int BW = 2;
   localparam int RW = 13;
   localparam int CW = 10;
   localparam int REFI = 400;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic          req_ready;
   logic [BW-1:0] req_bank = '0;
   logic [RW-1:0] req_row = '0;
   logic [CW-1:0] req_col = '0;
   logic [3:0]    cfg_tras = 4'd5;
   logic          cfg_trp_long = 1'b0;
   logic [6:0]    cfg_hit_limit = 7'd64;
   logic [7:0]    cfg_idle_limit = 8'd255;
   logic          cfg_ref_dual = 1'b0;
   logic [2:0]    cmd_op;
   logic [BW-1:0] cmd_bank;
   logic [RW-1:0] cmd_row;
   logic [CW-1:0] cmd_col;
   logic          cmd_ref_dual;

   always #5 clk = ~clk;

   sdram_bank_mgr #(.NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW), .REF_INTERVAL(REFI)) u_dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
      .cfg_tras(cfg_tras), .cfg_trp_long(cfg_trp_long), .cfg_hit_limit(cfg_hit_limit),
      .cfg_idle_limit(cfg_idle_limit), .cfg_ref_dual(cfg_ref_dual),
      .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
      .cmd_ref_dual(cmd_ref_dual)
   );

   int n_chk = 0, n_fail = 0;
   int mon_cyc = 0;
   bit sh_open [NB];
   int sh_row [NB], t_act [NB], t_pre [NB], t_acc [NB], hits [NB], n_act [NB], per_cnt [NB];
   int last_act = -1000, n_ref = 0;
   int ref_t [16];
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int trp_v();
      return cfg_trp_long ? 3 : 2;
   endfunction

   // Command monitor: shadow bank state checked against every command
   always @(negedge clk) begin
      if (rst) begin
         mon_cyc = 0;
         for (int b = 0; b < NB; b++) begin
            sh_open[b] = 1'b0; sh_row[b] = 0; t_act[b] = -1000; t_pre[b] = -1000;
            t_acc[b] = -1000; hits[b] = 0; n_act[b] = 0; per_cnt[b] = 0;
         end
         last_act = -1000;
         n_ref = 0;
      end else begin
         int b;
         mon_cyc++;
         b = int'(cmd_bank);
         case (cmd_op)
            3'd1: begin
               chk(!sh_open[b] && (mon_cyc - t_pre[b] >= trp_v()) &&
                   (mon_cyc - t_act[b] >= int'(cfg_tras) + trp_v()),
                   "R6", "activate spacing", mon_cyc - t_pre[b], trp_v());
               chk(mon_cyc - last_act >= 2, "R7", "activate gap", mon_cyc - last_act, 2);
               if (n_act[b] > 0) per_cnt[b] = hits[b];
               sh_open[b] = 1'b1; sh_row[b] = int'(cmd_row); t_act[b] = mon_cyc;
               hits[b] = 0; n_act[b]++; last_act = mon_cyc;
            end
            3'd2, 3'd3: begin
               chk(sh_open[b] && sh_row[b] == int'(cmd_row), "R3", "access to open row",
                   int'(cmd_row), sh_row[b]);
               chk(req_valid && req_ready && req_bank == cmd_bank && req_row == cmd_row &&
                   req_col == cmd_col && (req_write == (cmd_op == 3'd3)),
                   "R13", "access matches head request", int'(cmd_col), int'(req_col));
               hits[b]++;
               chk(hits[b] <= int'(cfg_hit_limit), "R8", "hits per activate",
                   hits[b], int'(cfg_hit_limit));
               t_acc[b] = mon_cyc;
            end
            3'd4: begin
               chk(sh_open[b] && (mon_cyc - t_act[b] >= int'(cfg_tras)), "R5",
                   "precharge after open time", mon_cyc - t_act[b], int'(cfg_tras));
               sh_open[b] = 1'b0; t_pre[b] = mon_cyc;
            end
            3'd5: begin
               for (int k = 0; k < NB; k++)
                  chk(!sh_open[k] && (mon_cyc - t_pre[k] >= trp_v()), "R11",
                      "refresh with banks idle", mon_cyc - t_pre[k], trp_v());
               chk(cmd_ref_dual == cfg_ref_dual, "R12", "dual-row flag",
                   int'(cmd_ref_dual), int'(cfg_ref_dual));
               if (n_ref < 16) ref_t[n_ref] = mon_cyc;
               n_ref++;
            end
            default: ;
         endcase
         if (cmd_op != 3'd5)
            chk(!cmd_ref_dual, "R12", "dual flag outside refresh", int'(cmd_ref_dual), 0);
      end
   end

   task automatic apply_reset();
      rst = 1'b1; req_valid = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
   endtask

   task automatic idle_cycles(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   // Called one time unit after a rising edge; returns likewise.
   task automatic do_req(input bit w, input int b, input int r, input int c,
                         output int waited, output int op_seen, output int rdy_cyc);
      req_valid = 1'b1; req_write = w; req_bank = BW'(b);
      req_row = RW'(r); req_col = CW'(c);
      waited = 0; op_seen = 0; rdy_cyc = 0;
      forever begin
         @(negedge clk); #1;
         waited++;
         if (req_ready) begin
            op_seen = int'(cmd_op); rdy_cyc = mon_cyc;
            break;
         end
         if (waited > 300) begin
            chk(0, "R13", "request never accepted", waited, 300);
            break;
         end
      end
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic traffic(input int ncyc);
      int w, o, rc;
      int start = mon_cyc;
      while (mon_cyc - start < ncyc) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[3:0] == 4'd0) idle_cycles(int'(lfsr[6:4]) + 1);
         else do_req(lfsr[4], int'(lfsr[6:5]), int'(lfsr[8:7]), int'(lfsr[15:9]), w, o, rc);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(0, "R13", "watchdog expired", 150000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int w, o, rc, a1;
      // R1, R2: reset state and first activate on each closed bank
      apply_reset();
      @(negedge clk); #1;
      chk(cmd_op == 3'd0, "R1", "command after reset", int'(cmd_op), 0);
      chk(!req_ready, "R1", "ready after reset", int'(req_ready), 0);
      @(posedge clk); #1;
      for (int b = 0; b < NB; b++) begin
         do_req(1'b0, b, 10 + b, b, w, o, rc);
         chk(w == 2, "R2", "closed-bank latency", w, 2);
         chk(t_act[b] == rc - 1, "R1", "activate right away after reset", t_act[b], rc - 1);
         chk(sh_row[b] == 10 + b, "R2", "activated row", sh_row[b], 10 + b);
      end
      // R3: hits, read and write codes
      for (int b = 0; b < NB; b++) begin
         do_req(b[0], b, 10 + b, 100 + b, w, o, rc);
         chk(w == 1, "R3", "hit latency", w, 1);
         chk(o == (b[0] ? 3 : 2), "R3", "access code", o, b[0] ? 3 : 2);
      end

      // R4, R5, R6: miss sequence swept over open and precharge times
      for (int tr = 5; tr <= 7; tr++) begin
         for (int pl = 0; pl < 2; pl++) begin
            cfg_tras = 4'(tr); cfg_trp_long = pl[0];
            apply_reset();
            do_req(1'b0, 1, 3, 0, w, o, rc);
            a1 = t_act[1];
            do_req(1'b1, 1, 4, 5, w, o, rc);
            chk(t_pre[1] - a1 == tr, "R5", "precharge waits open time", t_pre[1] - a1, tr);
            chk(t_act[1] - t_pre[1] == trp_v(), "R6", "activate after precharge",
                t_act[1] - t_pre[1], trp_v());
            chk(rc == t_act[1] + 1 && o == 3, "R4", "miss access after activate",
                rc, t_act[1] + 1);
         end
      end

      // R8: forced close after the hit limit
      cfg_tras = 4'd5; cfg_trp_long = 1'b0;
      for (int h = 8; h <= 64; h += 56) begin
         cfg_hit_limit = 7'(h);
         apply_reset();
         for (int k = 0; k <= h; k++) do_req(1'b0, 2, 7, k, w, o, rc);
         chk(n_act[2] == 2, "R8", "re-activate after limit", n_act[2], 2);
         chk(per_cnt[2] == h, "R8", "hits in first period", per_cnt[2], h);
      end
      cfg_hit_limit = 7'd64;

      // R9, R10: idle auto-close and close-page policy
      for (int li = 0; li < 3; li++) begin
         int lim = (li == 0) ? 10 : ((li == 1) ? 1 : 0);
         cfg_idle_limit = 8'(lim);
         apply_reset();
         do_req(1'b0, 3, 9, 1, w, o, rc);
         idle_cycles(20);
         if (lim == 10)
            chk(t_pre[3] - t_acc[3] == lim + 1, "R9", "idle close cycle",
                t_pre[3] - t_acc[3], lim + 1);
         else if (lim == 1)
            chk(t_pre[3] - t_act[3] == 5, "R9", "idle close held by open time",
                t_pre[3] - t_act[3], 5);
         else
            chk(t_pre[3] - t_act[3] == 5, "R10", "close-page precharge",
                t_pre[3] - t_act[3], 5);
      end
      cfg_idle_limit = 8'd255;

      // R11, R12: refresh period with no traffic, dual flag on and off
      for (int d = 0; d < 2; d++) begin
         cfg_ref_dual = d[0];
         apply_reset();
         idle_cycles(1250);
         chk(n_ref == 3, "R11", "refresh count idle", n_ref, 3);
         chk(ref_t[1] - ref_t[0] == REFI, "R11", "refresh spacing", ref_t[1] - ref_t[0], REFI);
         chk(ref_t[2] - ref_t[1] == REFI, "R11", "refresh spacing", ref_t[2] - ref_t[1], REFI);
      end

      // R11: refresh due while a request waits on a young page
      cfg_ref_dual = 1'b1;
      apply_reset();
      idle_cycles(397);
      do_req(1'b0, 0, 1, 0, w, o, rc);
      do_req(1'b0, 0, 1, 1, w, o, rc);
      do_req(1'b1, 0, 1, 2, w, o, rc);
      chk(n_ref == 1, "R11", "refresh during wait", n_ref, 1);
      chk(ref_t[0] - t_pre[0] == 2, "R11", "refresh after precharge", ref_t[0] - t_pre[0], 2);
      chk(t_act[0] > ref_t[0] && rc == ref_t[0] + 2, "R11", "request held across refresh",
          rc, ref_t[0] + 2);

      // R5, R6, R7, R8, R11, R13: random traffic over every timing setting
      cfg_hit_limit = 7'd8; cfg_idle_limit = 8'd12;
      for (int tr = 5; tr <= 7; tr++) begin
         for (int pl = 0; pl < 2; pl++) begin
            cfg_tras = 4'(tr); cfg_trp_long = pl[0]; cfg_ref_dual = pl[0];
            apply_reset();
            traffic(2030);
            chk(n_ref == 5, "R11", "refresh count under traffic", n_ref, 5);
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule